// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a 64-bit virtual address into a real address by walking up to five levels of translation tables held in memory: three region levels, a segment level and a page level. The address-space mode of a request chooses one of three space descriptors supplied on input ports; the type field of that descriptor sets the level at which the walk begins, and with it the range of virtual addresses that the walk may cover. Each table access is one 8-byte read on a memory port, and the walker waits as long as needed for each read to return.

A request carries the virtual address, an access kind (read, write or instruction fetch) and an address-space mode. The walker accepts one request at a time and answers it with a one-cycle response: a page-aligned real address and a permission set, or a fault code and a translation-exception identifier naming the faulting page and the address space used. Side inputs select 31-bit or 64-bit addressing, switch translation on or off, and give a prefix value that relocates the lowest 8 KiB of real storage. Caching of translations is left to the surrounding logic.

Top module: `pt_walker`

## Requirements
- R1: Mode encoding 0 selects `cr_primary` (space id 1), 1 selects `cr_secondary` (space id 2), 2 and 3 select `cr_home` (space id 3); in mode 1 a fetch (access code 2) uses `cr_primary` with space id 1, while reads (code 0) and writes (code 1) use `cr_secondary`.
- R2: Descriptor bits [3:2] give the start level (3 region-first, 2 region-second, 1 region-third, 0 segment) and bits [63:12] the table origin; each level reads the 8-byte entry at origin + 8 × index, with index VA[63:53], VA[52:42], VA[41:31], VA[30:20] and VA[19:12] for the five levels in walk order, one read per level.
- R3: Before any read, a region-second start faults if any of VA[63:53] is set, a region-third start if any of VA[63:42] is set, a segment start if any of VA[63:31] is set; the fault code is 1 (specification) and no table is read.
- R4: A region or segment entry whose bits [3:2] differ from the level code of the table it was read from ends the walk with fault code 1.
- R5: Entry bit 5 marks an entry invalid: in a region or segment entry it gives fault code 2, in a page entry fault code 3; the next-level origin or frame sits in bits [63:12].
- R6: Descriptor bit 6 ends the walk at once with real address equal to the page-aligned virtual address; with `xlate_en` low the page-aligned address passes through with all rights.
- R7: Page entry bit 9 removes write permission; a write to such a page gives fault code 4.
- R8: On any fault the identifier is the page-aligned virtual address ORed with the space id, plus value 4 for fault code 4; real address and permissions read zero.
- R9: Permissions are bit 0 read, bit 1 write, bit 2 execute, all three by default; in mode 1 a fetch keeps only execute and a data access loses execute.
- R10: With `addr64` low, the virtual address is cut to its low 31 bits before any check or walk.
- R11: A real result below 0x2000 has `prefix` added to it, whether it came from a page entry, a real-space descriptor or pass-through.
- R12: `req_ready` is high only when idle; a request is taken when `req_valid` and `req_ready` are both high, requests offered during a walk are ignored, each taken request yields exactly one `rsp_valid` pulse, and each table read is a one-cycle `mem_req_valid` pulse answered by `mem_rsp_valid` after any delay.
- R13: After reset `req_ready` is high and `rsp_valid` and `mem_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 64 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_mode | input | 2 | Address-space mode |
| cr_primary | input | 64 | Primary space descriptor |
| cr_secondary | input | 64 | Secondary space descriptor |
| cr_home | input | 64 | Home space descriptor |
| prefix | input | 64 | Relocation added to real results below 0x2000 |
| addr64 | input | 1 | 1: 64-bit addressing, 0: 31-bit |
| xlate_en | input | 1 | 1: translate, 0: pass through |
| mem_req_valid | output | 1 | Table read request, one cycle |
| mem_addr | output | 64 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Table entry |
| rsp_valid | output | 1 | Result pulse |
| rsp_real | output | 64 | Page-aligned real address |
| rsp_perm | output | 3 | Rights: bit 0 read, bit 1 write, bit 2 execute |
| rsp_fault | output | 3 | 0 none, 1 specification, 2 segment, 3 page, 4 protection |
| rsp_teid | output | 64 | Translation-exception identifier |

## Verification
A wrong level register shows at once on `mem_addr` as an index taken from the wrong bit field, and one response later as a changed count of table reads or a specification fault from the type check. A wrong choice of descriptor, space id or permission mask surfaces in the same response through the identifier's low bits and `rsp_perm`. A stuck walk state shows on the first cycle where `req_ready` differs from the idle/busy state predicted by the bench's model, and an extra or missing response pulse is caught on the cycle it occurs.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    // Walk level; the low two bits equal the type code an entry must carry.
    typedef enum logic [2:0] {
        LV_SEG  = 3'd0,
        LV_R3   = 3'd1,
        LV_R2   = 3'd2,
        LV_R1   = 3'd3,
        LV_PAGE = 3'd4
    } lvl_e;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_SPEC = 3'd1,
        FLT_SEG  = 3'd2,
        FLT_PAGE = 3'd3,
        FLT_PROT = 3'd4
    } flt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_DONE
    } st_e;

    localparam logic [1:0] ACC_RD = 2'd0;
    localparam logic [1:0] ACC_WR = 2'd1;
    localparam logic [1:0] ACC_FE = 2'd2;

    localparam logic [1:0] MODE_PRI = 2'd0;
    localparam logic [1:0] MODE_SEC = 2'd1;

    localparam int TYPE_LSB = 2;
    localparam int INV_BIT  = 5;
    localparam int REAL_BIT = 6;
    localparam int RO_BIT   = 9;

    localparam logic [2:0] PERM_ALL  = 3'b111;
    localparam logic [2:0] PERM_EXEC = 3'b100;
    localparam logic [2:0] PERM_DATA = 3'b011;
    localparam logic [2:0] PERM_NOWR = 3'b101;

endpackage

// File: rtl/ptw_select.sv
module ptw_select
    import ptw_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic [1:0]    mode,
    input  logic [1:0]    acc,
    input  logic [AW-1:0] cr_pri,
    input  logic [AW-1:0] cr_sec,
    input  logic [AW-1:0] cr_home,
    input  logic [AW-1:0] va,
    output logic [AW-1:0] desc,
    output logic [1:0]    sid,
    output logic [2:0]    perm_mask,
    output lvl_e          start_lvl,
    output logic          range_bad
);

    logic unused_va;
    assign unused_va = ^va[30:0];

    always_comb begin
        perm_mask = PERM_ALL;
        if (mode == MODE_SEC) begin
            if (acc == ACC_FE) begin
                desc      = cr_pri;
                sid       = 2'd1;
                perm_mask = PERM_EXEC;
            end else begin
                desc      = cr_sec;
                sid       = 2'd2;
                perm_mask = PERM_DATA;
            end
        end else if (mode == MODE_PRI) begin
            desc = cr_pri;
            sid  = 2'd1;
        end else begin
            desc = cr_home;
            sid  = 2'd3;
        end
    end

    always_comb begin
        start_lvl = lvl_e'({1'b0, desc[TYPE_LSB+1:TYPE_LSB]});
        case (desc[TYPE_LSB+1:TYPE_LSB])
            2'd3:    range_bad = 1'b0;
            2'd2:    range_bad = |va[63:53];
            2'd1:    range_bad = |va[63:42];
            default: range_bad = |va[63:31];
        endcase
    end

endmodule

// File: rtl/ptw_index.sv
module ptw_index
    import ptw_pkg::*;
#(
    parameter int AW = 64,
    parameter int PS = 12
) (
    input  lvl_e             lvl,
    input  logic [AW-1:0]    va,
    input  logic [AW-PS-1:0] origin,
    output logic [AW-1:0]    addr
);

    localparam int IDX_W = 11;
    localparam int ENT_SH = 3;

    logic [IDX_W-1:0] idx;
    logic unused_low;
    assign unused_low = ^va[PS-1:0];

    always_comb begin
        case (lvl)
            LV_R1:   idx = va[63:53];
            LV_R2:   idx = va[52:42];
            LV_R3:   idx = va[41:31];
            LV_SEG:  idx = va[30:20];
            default: idx = {3'b000, va[19:12]};
        endcase
        addr = {origin, {PS{1'b0}}}
             + {{(AW-IDX_W-ENT_SH){1'b0}}, idx, {ENT_SH{1'b0}}};
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int          AW        = 64,
    parameter int          PS        = 12,
    parameter logic [63:0] PFX_LIMIT = 64'h2000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_va,
    input  logic [1:0]    req_acc,
    input  logic [1:0]    req_mode,
    input  logic [AW-1:0] cr_primary,
    input  logic [AW-1:0] cr_secondary,
    input  logic [AW-1:0] cr_home,
    input  logic [AW-1:0] prefix,
    input  logic          addr64,
    input  logic          xlate_en,
    output logic          mem_req_valid,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rsp_valid,
    input  logic [AW-1:0] mem_rsp_data,
    output logic          rsp_valid,
    output logic [AW-1:0] rsp_real,
    output logic [2:0]    rsp_perm,
    output logic [2:0]    rsp_fault,
    output logic [AW-1:0] rsp_teid
);

    localparam int FW = AW - PS;

    typedef struct packed {
        st_e           st;
        lvl_e          lvl;
        logic [AW-1:0] va;
        logic [FW-1:0] org;
        logic [1:0]    sid;
        logic [2:0]    pmask;
        logic          wr;
        logic [AW-1:0] real_a;
        logic [2:0]    perm;
        flt_e          flt;
        logic [AW-1:0] teid;
    } walk_t;

    walk_t q, d;

    logic [AW-1:0] va_m, va_pg, sel_desc, idx_addr;
    logic [1:0]    sel_sid;
    logic [2:0]    sel_mask;
    lvl_e          sel_lvl;
    logic          sel_range_bad;

    function automatic logic [AW-1:0] relocate(input logic [AW-1:0] a,
                                               input logic [AW-1:0] pfx);
        return (a < PFX_LIMIT[AW-1:0]) ? a + pfx : a;
    endfunction

    function automatic logic [AW-1:0] make_teid(input logic [AW-1:0] va_a,
                                                input logic [1:0] s,
                                                input logic prot);
        return va_a | {{(AW-3){1'b0}}, prot, s};
    endfunction

    assign va_m  = addr64 ? req_va : {{(AW-31){1'b0}}, req_va[30:0]};
    assign va_pg = {va_m[AW-1:PS], {PS{1'b0}}};

    ptw_select #(.AW(AW)) u_select (
        .mode      (req_mode),
        .acc       (req_acc),
        .cr_pri    (cr_primary),
        .cr_sec    (cr_secondary),
        .cr_home   (cr_home),
        .va        (va_pg),
        .desc      (sel_desc),
        .sid       (sel_sid),
        .perm_mask (sel_mask),
        .start_lvl (sel_lvl),
        .range_bad (sel_range_bad)
    );

    ptw_index #(.AW(AW), .PS(PS)) u_index (
        .lvl    (q.lvl),
        .va     (q.va),
        .origin (q.org),
        .addr   (idx_addr)
    );

    logic unused_bits;
    assign unused_bits = ^{mem_rsp_data[11:10], mem_rsp_data[8:6],
                           mem_rsp_data[4], mem_rsp_data[1:0],
                           sel_desc[11:7], sel_desc[5:0], va_m[PS-1:0]};

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.va     = va_pg;
                    d.sid    = sel_sid;
                    d.pmask  = sel_mask;
                    d.wr     = (req_acc == ACC_WR);
                    d.real_a = '0;
                    d.perm   = '0;
                    d.flt    = FLT_NONE;
                    d.teid   = '0;
                    if (!xlate_en) begin
                        d.real_a = relocate(va_pg, prefix);
                        d.perm   = PERM_ALL;
                        d.st     = ST_DONE;
                    end else if (sel_range_bad) begin
                        d.flt  = FLT_SPEC;
                        d.teid = make_teid(va_pg, sel_sid, 1'b0);
                        d.st   = ST_DONE;
                    end else if (sel_desc[REAL_BIT]) begin
                        d.real_a = relocate(va_pg, prefix);
                        d.perm   = sel_mask;
                        d.st     = ST_DONE;
                    end else begin
                        d.lvl = sel_lvl;
                        d.org = sel_desc[AW-1:PS];
                        d.st  = ST_FETCH;
                    end
                end
            end
            ST_FETCH: d.st = ST_WAIT;
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (q.lvl == LV_PAGE) begin
                        d.st = ST_DONE;
                        if (mem_rsp_data[INV_BIT]) begin
                            d.flt  = FLT_PAGE;
                            d.teid = make_teid(q.va, q.sid, 1'b0);
                        end else if (mem_rsp_data[RO_BIT] && q.wr) begin
                            d.flt  = FLT_PROT;
                            d.teid = make_teid(q.va, q.sid, 1'b1);
                        end else begin
                            d.real_a = relocate({mem_rsp_data[AW-1:PS], {PS{1'b0}}}, prefix);
                            d.perm   = q.pmask & (mem_rsp_data[RO_BIT] ? PERM_NOWR : PERM_ALL);
                        end
                    end else if (mem_rsp_data[INV_BIT]) begin
                        d.flt  = FLT_SEG;
                        d.teid = make_teid(q.va, q.sid, 1'b0);
                        d.st   = ST_DONE;
                    end else if (mem_rsp_data[TYPE_LSB+1:TYPE_LSB] != q.lvl[1:0]) begin
                        d.flt  = FLT_SPEC;
                        d.teid = make_teid(q.va, q.sid, 1'b0);
                        d.st   = ST_DONE;
                    end else begin
                        d.org = mem_rsp_data[AW-1:PS];
                        d.lvl = (q.lvl == LV_SEG) ? LV_PAGE : lvl_e'(q.lvl - 3'd1);
                        d.st  = ST_FETCH;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready     = (q.st == ST_IDLE);
    assign mem_req_valid = (q.st == ST_FETCH);
    assign mem_addr      = idx_addr;
    assign rsp_valid     = (q.st == ST_DONE);
    assign rsp_real      = q.real_a;
    assign rsp_perm      = q.perm;
    assign rsp_fault     = q.flt;
    assign rsp_teid      = q.teid;

    // Table reads are single-cycle pulses followed by a wait.
    assert_mem_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // A response is one cycle long and the walker is idle right after it.
    assert_rsp_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // A taken request makes the walker busy on the next cycle.
    assert_accept_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // Entry reads are 8-byte aligned.
    assert_entry_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_addr[2:0] == 3'b000));

    // A fault identifier always names an address space.
    assert_teid_space_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_teid[1:0] != 2'b00));

    // Protection faults carry the extra identifier bit and grant nothing.
    assert_prot_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_PROT) |-> (rsp_teid[2] && rsp_perm == 3'b000));

endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_va = '0;
    logic [1:0]  req_acc = '0;
    logic [1:0]  req_mode = '0;
    logic [63:0] cr_primary = '0, cr_secondary = '0, cr_home = '0;
    logic [63:0] prefix = '0;
    logic        addr64 = 1'b1;
    logic        xlate_en = 1'b1;
    logic        mem_req_valid;
    logic [63:0] mem_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic [63:0] rsp_real, rsp_teid;
    logic [2:0]  rsp_perm, rsp_fault;

    int n_cmp = 0;
    int n_bad = 0;
    int reads_seen = 0;
    int lat = 1;
    bit done = 0;

    logic [63:0] mem [logic [63:0]];

    logic [63:0] got_real, got_teid;
    logic [2:0]  got_perm, got_fault;

    always #2.5 clk = ~clk;

    pt_walker uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_acc(req_acc), .req_mode(req_mode),
        .cr_primary(cr_primary), .cr_secondary(cr_secondary), .cr_home(cr_home),
        .prefix(prefix), .addr64(addr64), .xlate_en(xlate_en),
        .mem_req_valid(mem_req_valid), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_real(rsp_real), .rsp_perm(rsp_perm),
        .rsp_fault(rsp_fault), .rsp_teid(rsp_teid)
    );

    function automatic logic [63:0] rd(input logic [63:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'd0;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Behavioural reference walk.
    function automatic void model(input logic [63:0] va_in, input logic [1:0] acc,
                                  input logic [1:0] mode, input bit a64, input bit en,
                                  output logic [63:0] r_real, output logic [2:0] r_perm,
                                  output logic [2:0] r_flt, output logic [63:0] r_teid,
                                  output int r_reads);
        logic [63:0] va, desc, org, e;
        logic [2:0]  mask;
        int sp, lv;
        bit bad;
        va = a64 ? va_in : (va_in & 64'h7fff_ffff);
        va = va & ~64'hfff;
        r_real = 0; r_perm = 0; r_flt = 0; r_teid = 0; r_reads = 0;
        if (!en) begin
            r_real = (va < 64'h2000) ? va + prefix : va;
            r_perm = 3'b111;
            return;
        end
        mask = 3'b111;
        if (mode == 2'd1 && acc == 2'd2) begin desc = cr_primary; sp = 1; mask = 3'b100; end
        else if (mode == 2'd1) begin desc = cr_secondary; sp = 2; mask = 3'b011; end
        else if (mode == 2'd0) begin desc = cr_primary; sp = 1; end
        else begin desc = cr_home; sp = 3; end
        lv = int'(desc[3:2]);
        bad = 0;
        if (lv < 3 && (va >> (20 + 11 * (lv + 1))) != 0) bad = 1;
        if (bad) begin r_flt = 1; r_teid = va | 64'(sp); return; end
        if (desc[6]) begin
            r_real = (va < 64'h2000) ? va + prefix : va;
            r_perm = mask;
            return;
        end
        org = desc & ~64'hfff;
        while (lv >= 0) begin
            e = rd(org + (((va >> (20 + 11 * lv)) & 64'h7ff) << 3));
            r_reads++;
            if (e[5]) begin r_flt = 2; r_teid = va | 64'(sp); return; end
            if (int'(e[3:2]) != lv) begin r_flt = 1; r_teid = va | 64'(sp); return; end
            org = e & ~64'hfff;
            lv--;
        end
        e = rd(org + (((va >> 12) & 64'hff) << 3));
        r_reads++;
        if (e[5]) begin r_flt = 3; r_teid = va | 64'(sp); return; end
        if (e[9] && acc == 2'd1) begin r_flt = 4; r_teid = va | 64'(sp) | 64'd4; return; end
        r_perm = e[9] ? (mask & 3'b101) : mask;
        r_real = e & ~64'hfff;
        if (r_real < 64'h2000) r_real = r_real + prefix;
    endfunction

    // Memory responder with a variable delay.
    initial begin
        logic [63:0] a;
        forever begin
            @(negedge clk);
            while (mem_req_valid) begin
                a = mem_addr;
                reads_seen++;
                repeat (lat) @(negedge clk);
                mem_rsp_data  = rd(a);
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = '0;
            end
        end
    end

    task automatic run(input string tag, input logic [63:0] va, input logic [1:0] acc,
                       input logic [1:0] mode, input bit spam);
        logic [63:0] e_real, e_teid;
        logic [2:0]  e_perm, e_flt;
        int e_reads;
        bit seen;
        model(va, acc, mode, addr64, xlate_en, e_real, e_perm, e_flt, e_teid, e_reads);
        @(negedge clk);
        check({tag, " R12 ready before request"}, 64'(req_ready), 64'd1);
        reads_seen = 0;
        req_va = va; req_acc = acc; req_mode = mode; req_valid = 1'b1;
        @(negedge clk);
        if (spam) begin
            req_va = va ^ 64'h0010_0000_0000_0000; req_acc = 2'd1;
        end else begin
            req_valid = 1'b0;
        end
        seen = 0;
        while (!seen) begin
            if (rsp_valid) begin
                seen = 1;
                req_valid = 1'b0;
                got_real = rsp_real; got_perm = rsp_perm;
                got_fault = rsp_fault; got_teid = rsp_teid;
            end else begin
                check({tag, " R12 busy during walk"}, 64'(req_ready), 64'd0);
                check({tag, " R12 no early response"}, 64'(rsp_valid), 64'd0);
                @(negedge clk);
            end
        end
        check({tag, " real"}, got_real, e_real);
        check({tag, " perm"}, 64'(got_perm), 64'(e_perm));
        check({tag, " fault"}, 64'(got_fault), 64'(e_flt));
        check({tag, " teid"}, got_teid, e_teid);
        check({tag, " R2 read count"}, 64'(reads_seen), 64'(e_reads));
        @(negedge clk);
        check({tag, " R12 single pulse"}, 64'(rsp_valid), 64'd0);
        check({tag, " R12 idle after"}, 64'(req_ready), 64'd1);
        lat = (lat % 3) + 1;
    endtask

    localparam logic [63:0] VA_A  = (64'd1 << 53) | (64'd2 << 42) | (64'd3 << 31)
                                  | (64'd4 << 20) | (64'd5 << 12) | 64'habc;
    localparam logic [63:0] VA_S  = (64'd3 << 31) | (64'd4 << 20) | (64'd6 << 12);
    localparam logic [63:0] VA_H  = (64'd4 << 20) | (64'd7 << 12);
    localparam logic [63:0] VA_R2 = (64'd2 << 42) | (64'd3 << 31) | (64'd4 << 20) | (64'd5 << 12);

    initial begin
        // primary chain, region-first start
        cr_primary = 64'h10_0000 | 64'hC;
        mem[64'h10_0008] = 64'h10_1000 | 64'hC;
        mem[64'h10_1010] = 64'h10_2000 | 64'h8;
        mem[64'h10_2018] = 64'h10_3000 | 64'h4;
        mem[64'h10_3020] = 64'h10_4000;
        mem[64'h10_4028] = 64'hABCD000;
        mem[64'h10_0010] = 64'h10_5000 | 64'h4;          // wrong type in region-first table
        // secondary chain, region-third start
        cr_secondary = 64'h20_0000 | 64'h4;
        mem[64'h20_0018] = 64'h20_1000 | 64'h4;
        mem[64'h20_1020] = 64'h20_2000;
        mem[64'h20_2030] = 64'h5000 | 64'h200;            // read-only page
        // home chain, segment start
        cr_home = 64'h30_0000;
        mem[64'h30_0020] = 64'h30_1000;
        mem[64'h30_1038] = 64'h1000;                      // low frame, relocated
        mem[64'h30_0040] = 64'h20;                        // invalid segment entry
        mem[64'h30_1048] = 64'h20;                        // invalid page entry
        mem[64'h40_0010] = 64'h10_2000 | 64'h8;           // region-second start table
        prefix = 64'h4_0000;

        repeat (3) @(negedge clk);
        check("R13 ready in reset", 64'(req_ready), 64'd1);
        check("R13 no response in reset", 64'(rsp_valid), 64'd0);
        check("R13 no read in reset", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R13 ready after reset", 64'(req_ready), 64'd1);

        run("R2 primary five-level read", VA_A, 2'd0, 2'd0, 0);
        check("R2 frame explicit", got_real, 64'hABCD000);
        run("R12 requests during walk ignored", VA_A, 2'd0, 2'd0, 1);
        check("R12 spam result kept", 64'(got_perm), 64'h7);
        run("R4 type mismatch", VA_A ^ (64'd3 << 53), 2'd0, 2'd0, 0);
        check("R4 fault code", 64'(got_fault), 64'd1);
        run("R5 segment invalid", (64'd8 << 20), 2'd0, 2'd2, 0);
        check("R5 segment code", 64'(got_fault), 64'd2);
        run("R5 page invalid", (64'd4 << 20) | (64'd9 << 12), 2'd0, 2'd2, 0);
        check("R5 page code", 64'(got_fault), 64'd3);
        run("R11 home low frame", VA_H, 2'd0, 2'd2, 0);
        check("R11 relocated explicit", got_real, 64'h4_1000);
        run("R1 mode 3 is home", VA_H, 2'd0, 2'd3, 0);
        run("R9 secondary read", VA_S, 2'd0, 2'd1, 0);
        check("R9 read only rights", 64'(got_perm), 64'd1);
        run("R7 secondary write protected", VA_S, 2'd1, 2'd1, 0);
        check("R7 protection teid", got_teid, VA_S | 64'd6);
        run("R1 secondary fetch uses primary", VA_A, 2'd2, 2'd1, 0);
        check("R9 fetch rights", 64'(got_perm), 64'd4);
        run("R8 secondary fetch fault space 1", VA_A ^ (64'd3 << 53), 2'd2, 2'd1, 0);
        check("R8 teid explicit", got_teid, ((VA_A ^ (64'd3 << 53)) & ~64'hfff) | 64'd1);
        run("R3 region-third range", VA_S | (64'd1 << 42), 2'd0, 2'd1, 0);
        run("R3 segment range", VA_H | (64'd1 << 31), 2'd0, 2'd2, 0);
        check("R3 segment range code", 64'(got_fault), 64'd1);
        addr64 = 1'b0;
        run("R10 31-bit mask", VA_H | (64'd1 << 31) | (64'd1 << 40), 2'd0, 2'd2, 0);
        check("R10 masked result", got_real, 64'h4_1000);
        addr64 = 1'b1;
        cr_home = 64'h40_0000 | 64'h8;
        run("R3 region-second range", VA_R2 | (64'd1 << 53), 2'd0, 2'd2, 0);
        run("R2 region-second walk", VA_R2, 2'd1, 2'd2, 0);
        check("R2 region-second frame", got_real, 64'hABCD000);
        cr_primary = cr_primary | 64'h40;
        run("R6 real-space descriptor", VA_A, 2'd1, 2'd0, 0);
        check("R6 real equals virtual", got_real, VA_A & ~64'hfff);
        run("R11 real-space low address", 64'h1234, 2'd0, 2'd0, 0);
        cr_primary = cr_primary & ~64'h40;
        xlate_en = 1'b0;
        run("R6 translation off low", 64'h1abc, 2'd1, 2'd0, 0);
        check("R11 pass-through relocated", got_real, 64'h4_1000);
        run("R6 translation off high", 64'h1234_5678_9000, 2'd2, 2'd1, 0);
        xlate_en = 1'b1;

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R12 watchdog expired actual=hung expected=response");
            summary();
            $finish;
        end
    end

endmodule